// File: doc/BRIEF.md
# Exponential Retry Backoff Controller

This block watches one requester that retries an atomic compare-and-swap. Each time the requester reports a failed attempt, the block asks for a stall. The stall gets longer, by powers of two, as failures repeat, so that a requester that keeps losing steps back and leaves the shared resource to others. A success report ends the episode and returns the backoff to its shortest length.

There are two ways to stall. In pause mode the block sends the whole scaled stall length as one request to a downstream pause counter. The pause unit reports `busy_i` while it is counting. In slot mode the block does the waiting itself: it raises `wait_o` for a whole number of fixed-length dummy-wait slots. Failures that arrive while a stall is still running are queued and are not dropped. The mode input is only taken when nothing is in flight.

Top module: `retry_backoff`

## Requirements
- R1: After reset the spin count is 1, `req_valid_o` is 0 and `wait_o` is 0.
- R2: In pause mode an accepted failure raises `req_valid_o` in the cycle after the failure strobe is sampled. `req_amount_o` then equals the spin count multiplied by 128 (shifted left by 7). The first failure after reset therefore requests 128.
- R3: Each issued stall doubles the spin count, so successive failures request 128, 256, 512 and so on.
- R4: The spin count saturates at 4096. Further failures keep requesting 4096 × 128 = 524288.
- R5: A success strobe returns the spin count to 1 and discards any held failures. When success and failure strobes coincide, success wins, the failure is dropped and no request follows.
- R6: `req_valid_o` is high for exactly one cycle per issued stall. At least one low cycle separates two requests.
- R7: A failure that arrives while `busy_i` is high is held. It is issued in the cycle after the first sampled edge with `busy_i` low. Up to 7 held failures are each issued separately, in turn, and each one doubles the count.
- R8: In slot mode an issued failure raises `wait_o` from the next cycle for exactly spin count × 3 × slot-length cycles. The count doubles as in pause mode, and no pause request is made.
- R9: The mode input is sampled only when no stall is pending, busy or running. A held failure uses the mode that was in force when it was queued.
- R10: A failure that arrives during a slot-mode wait is held. Its wait starts after exactly one low cycle of `wait_o` following the end of the current wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_i | input | 1 | One-cycle strobe: CAS attempt failed |
| succ_i | input | 1 | One-cycle strobe: CAS attempt succeeded |
| mode_i | input | 1 | 0 = pause request, 1 = dummy-wait slots |
| busy_i | input | 1 | Downstream pause unit is counting |
| req_valid_o | output | 1 | One-cycle stall request to the pause unit |
| req_amount_o | output | 20 | Stall length in cycles, valid with `req_valid_o` |
| wait_o | output | 1 | High while slot-mode dummy waits run |

## Verification
A pause request is due one clock edge after the failure strobe is sampled. A held failure is due one edge after `busy_i` is first sampled low. A queued follow-on request is due two edges after the previous one. A slot-mode wait rises one edge after the strobe and lasts count × 3 × slot-length cycles. The bench drives inputs and samples outputs on falling edges, so every check reads the value registered at the rising edge that precedes it. A reference model that advances one step per cycle predicts valid and amount for the random phase, and the directed cases count falling edges to measure wait lengths and gaps.

// File: rtl/retry_backoff_pkg.sv
package retry_backoff_pkg;
   typedef enum logic {
      BK_PAUSE = 1'b0,
      BK_SLOTS = 1'b1
   } bk_mode_e;
endpackage

// File: rtl/bko_spin_ctr.sv
// One-hot spin count: starts at 1, doubles on each step, saturates at LIMIT.
module bko_spin_ctr #(
   parameter int unsigned LIMIT = 4096,
   parameter int unsigned CNT_W = $clog2(LIMIT) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CEIL = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clear_i)
         cnt_d = ONE;
      else if (step_i)
         cnt_d = (cnt_q >= CEIL) ? CEIL : (cnt_q << 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= ONE;
      else
         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   AST_CNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(cnt_o)); // R3
   AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= CEIL); // R4
   AST_CLEAR_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> cnt_o == ONE); // R5
endmodule

// File: rtl/bko_pend_ctr.sv
// Saturating count of failures waiting for the stall path to free up.
module bko_pend_ctr #(
   parameter int unsigned PEND_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_i,
   input  logic add_i,
   input  logic take_i,
   output logic has_o
);
   localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

   logic [PEND_W-1:0] pend_q;
   logic [PEND_W-1:0] pend_d;

   always_comb begin
      pend_d = pend_q;
      if (flush_i)
         pend_d = '0;
      else if (add_i && !take_i)
         pend_d = (pend_q == PMAX) ? PMAX : pend_q + 1'b1;
      else if (!add_i && take_i)
         pend_d = pend_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= pend_d;
   end

   assign has_o = (pend_q != '0);

   AST_TAKE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> (has_o || add_i)); // R7
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !has_o); // R5
endmodule

// File: rtl/bko_slot_timer.sv
// Runs a number of fixed-length dummy-wait slots back to back.
module bko_slot_timer #(
   parameter int unsigned SLOT_CYC = 45,
   parameter int unsigned SLOTS_W  = 15,
   parameter int unsigned TMR_W    = $clog2(SLOT_CYC) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [SLOTS_W-1:0] slots_i,
   output logic               active_o
);
   localparam logic [TMR_W-1:0] RELOAD = TMR_W'(SLOT_CYC - 1);

   logic               active_q;
   logic [SLOTS_W-1:0] slots_q;
   logic [TMR_W-1:0]   tmr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         slots_q  <= '0;
         tmr_q    <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         slots_q  <= slots_i;
         tmr_q    <= RELOAD;
      end else if (active_q) begin
         if (tmr_q == '0) begin
            tmr_q <= RELOAD;
            if (slots_q <= SLOTS_W'(1))
               active_q <= 1'b0;
            else
               slots_q <= slots_q - 1'b1;
         end else begin
            tmr_q <= tmr_q - 1'b1;
         end
      end
   end

   assign active_o = active_q;

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !active_o); // R10
   AST_START_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> slots_i != '0); // R8
endmodule

// File: rtl/retry_backoff.sv
module retry_backoff
   import retry_backoff_pkg::*;
#(
   parameter int unsigned LIMIT          = 4096,
   parameter int unsigned SHIFT          = 7,
   parameter int unsigned SLOTS_PER_UNIT = 3,
   parameter int unsigned SLOT_CYC       = 45,
   parameter int unsigned PEND_W         = 3,
   parameter bit          HAS_SLOTS      = 1'b1,
   parameter int unsigned CNT_W          = $clog2(LIMIT) + 1,
   parameter int unsigned AMT_W          = CNT_W + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fail_i,
   input  logic             succ_i,
   input  logic             mode_i,
   input  logic             busy_i,
   output logic             req_valid_o,
   output logic [AMT_W-1:0] req_amount_o,
   output logic             wait_o
);
   localparam int unsigned SLOTS_W = $clog2(LIMIT * SLOTS_PER_UNIT) + 1;

   // elaboration-time parameter checks
   if (LIMIT < 2 || (LIMIT & (LIMIT - 1)) != 0) begin : g_bad_limit
      $error("retry_backoff: LIMIT must be a power of two of at least 2");
   end
   if (SLOT_CYC < 1 || SLOTS_PER_UNIT < 1) begin : g_bad_slot
      $error("retry_backoff: slot length and slots per unit must be nonzero");
   end
   if (PEND_W < 1) begin : g_bad_pend
      $error("retry_backoff: PEND_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             pend_has;
   logic             slot_active;
   bk_mode_e         mode_q;
   bk_mode_e         mode_eff;
   logic             vld_q;
   logic [AMT_W-1:0] amt_q;
   logic             idle;
   logic             can_issue;
   logic             go;
   logic             go_pause;
   logic             go_slots;

   assign can_issue = !busy_i && !slot_active && !vld_q;
   assign idle      = can_issue && !pend_has;
   assign go        = (pend_has || fail_i) && can_issue && !succ_i;
   assign go_pause  = go && (mode_eff == BK_PAUSE);
   assign go_slots  = go && (mode_eff == BK_SLOTS);

   bko_spin_ctr #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_spin (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (succ_i),
      .step_i  (go),
      .cnt_o   (cnt)
   );

   bko_pend_ctr #(.PEND_W(PEND_W)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (succ_i),
      .add_i   (fail_i),
      .take_i  (go),
      .has_o   (pend_has)
   );

   if (HAS_SLOTS) begin : g_slots
      logic [SLOTS_W-1:0] slot_total;
      assign slot_total = SLOTS_W'(cnt) * SLOTS_W'(SLOTS_PER_UNIT);
      assign mode_eff   = idle ? bk_mode_e'(mode_i) : mode_q;

      bko_slot_timer #(.SLOT_CYC(SLOT_CYC), .SLOTS_W(SLOTS_W)) u_slots (
         .clk      (clk),
         .rst_n    (rst_n),
         .start_i  (go_slots),
         .slots_i  (slot_total),
         .active_o (slot_active)
      );
   end else begin : g_pause_only
      assign mode_eff    = BK_PAUSE;
      assign slot_active = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         amt_q  <= '0;
         mode_q <= BK_PAUSE;
      end else begin
         vld_q <= go_pause;
         if (go_pause)
            amt_q <= AMT_W'(cnt) << SHIFT;
         if (idle)
            mode_q <= bk_mode_e'(mode_i);
      end
   end

   assign req_valid_o  = vld_q;
   assign req_amount_o = amt_q;
   assign wait_o       = slot_active;

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |=> !req_valid_o); // R6
   AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid_o) |-> !$past(busy_i)); // R7
   AST_AMT_SCALED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (req_amount_o[SHIFT-1:0] == '0 && req_amount_o != '0)); // R2
   AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid_o && $rose(wait_o))); // R8
   AST_SUCC_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      succ_i |=> !$rose(req_valid_o)); // R5
endmodule

// File: tb/retry_backoff_bench.sv
module retry_backoff_bench;
   localparam int unsigned LIMIT = 4096;
   localparam int unsigned SHIFT = 7;
   localparam int unsigned SPU   = 3;
   localparam int unsigned SLOT  = 6;
   localparam int unsigned AMT_W = $clog2(LIMIT) + 1 + SHIFT;

   logic clk = 1'b0;
   logic rst_n, fail_i, succ_i, mode_i, busy_i;
   logic req_valid_o, wait_o;
   logic [AMT_W-1:0] req_amount_o;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   retry_backoff #(
      .LIMIT(LIMIT), .SHIFT(SHIFT), .SLOTS_PER_UNIT(SPU), .SLOT_CYC(SLOT)
   ) u_retry_backoff (
      .clk(clk), .rst_n(rst_n), .fail_i(fail_i), .succ_i(succ_i),
      .mode_i(mode_i), .busy_i(busy_i), .req_valid_o(req_valid_o),
      .req_amount_o(req_amount_o), .wait_o(wait_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint exp_amt(input int k);
      longint c = (k >= 12) ? longint'(LIMIT) : (longint'(1) << k);
      return c << SHIFT;
   endfunction

   task automatic fail_once();
      fail_i = 1'b1;
      @(negedge clk);
      fail_i = 1'b0;
   endtask

   task automatic succ_once();
      succ_i = 1'b1;
      @(negedge clk);
      succ_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic measure_wait(output int n);
      n = 0;
      while (wait_o && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n;
      int m_cnt, m_pend, m_vld;
      longint m_amt;
      rst_n = 1'b0; fail_i = 1'b0; succ_i = 1'b0; mode_i = 1'b0; busy_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", req_valid_o, 0);
      chk("R1 wait after reset", wait_o, 0);

      // doubling to saturation
      for (int k = 0; k < 14; k++) begin
         fail_once();
         chk("R2 R6 valid on failure", req_valid_o, 1);
         chk(k < 12 ? "R3 doubling amount" : "R4 saturated amount", req_amount_o, exp_amt(k));
         @(negedge clk);
         chk("R6 single-cycle valid", req_valid_o, 0);
      end

      // success reset
      succ_once();
      fail_once();
      chk("R5 amount after success", req_amount_o, 128);
      @(negedge clk);
      // success and failure together
      succ_i = 1'b1; fail_i = 1'b1;
      @(negedge clk);
      succ_i = 1'b0; fail_i = 1'b0;
      chk("R5 coincident strobes no request", req_valid_o, 0);
      @(negedge clk);
      chk("R5 coincident strobes no late request", req_valid_o, 0);
      fail_once();
      chk("R5 count reset by coincident success", req_amount_o, 128);
      @(negedge clk);

      // busy hold, count now 2
      busy_i = 1'b1;
      fail_once();
      for (int i = 0; i < 4; i++) begin
         chk("R7 held while busy", req_valid_o, 0);
         @(negedge clk);
      end
      busy_i = 1'b0;
      @(negedge clk);
      chk("R7 issued after busy drops", req_valid_o, 1);
      chk("R7 held amount", req_amount_o, 256);
      @(negedge clk);

      // two held failures, count now 4
      busy_i = 1'b1;
      fail_once();
      fail_once();
      busy_i = 1'b0;
      @(negedge clk);
      chk("R7 first queued valid", req_valid_o, 1);
      chk("R7 first queued amount", req_amount_o, 512);
      @(negedge clk);
      chk("R6 gap between queued", req_valid_o, 0);
      @(negedge clk);
      chk("R7 second queued valid", req_valid_o, 1);
      chk("R7 second queued amount", req_amount_o, 1024);
      @(negedge clk);
      succ_once();

      // mode change while held is ignored
      busy_i = 1'b1;
      fail_once();
      mode_i = 1'b1;
      @(negedge clk);
      busy_i = 1'b0;
      @(negedge clk);
      chk("R9 held failure keeps pause mode", req_valid_o, 1);
      chk("R9 held failure amount", req_amount_o, 128);
      chk("R9 no slot wait", wait_o, 0);
      @(negedge clk);
      @(negedge clk);

      // slot mode
      succ_once();
      fail_once();
      chk("R8 no pause request in slot mode", req_valid_o, 0);
      chk("R8 wait raised", wait_o, 1);
      measure_wait(n);
      chk("R8 wait length count 1", n, SPU * SLOT);
      fail_once();
      measure_wait(n);
      chk("R8 wait length count 2", n, 2 * SPU * SLOT);
      fail_once();
      repeat (5) @(negedge clk);
      fail_once();
      measure_wait(n);
      chk("R10 gap low", wait_o, 0);
      @(negedge clk);
      chk("R10 held wait starts", wait_o, 1);
      measure_wait(n);
      chk("R10 held wait length count 8", n, 8 * SPU * SLOT);

      // random pause-mode phase
      mode_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      succ_once();
      void'($urandom(32'd1234));
      m_cnt = 1; m_pend = 0; m_vld = 0; m_amt = 0;
      for (int c = 0; c < 3000; c++) begin
         int can, go, f, s, b;
         chk("R2 R6 random valid", req_valid_o, m_vld);
         if (m_vld != 0) chk("R3 R4 random amount", req_amount_o, m_amt);
         f = (($urandom % 6) == 0) ? 1 : 0;
         s = (($urandom % 20) == 0) ? 1 : 0;
         b = (($urandom % 3) == 0) ? 1 : 0;
         fail_i = f[0]; succ_i = s[0]; busy_i = b[0];
         can = (b == 0 && m_vld == 0) ? 1 : 0;
         go  = ((m_pend != 0 || f != 0) && can != 0 && s == 0) ? 1 : 0;
         m_vld = go;
         if (go != 0) m_amt = longint'(m_cnt) << SHIFT;
         if (s != 0) begin
            m_pend = 0;
            m_cnt  = 1;
         end else begin
            m_pend = m_pend + f - go;
            if (m_pend > 7) m_pend = 7;
            if (go != 0) m_cnt = (m_cnt >= int'(LIMIT)) ? int'(LIMIT) : m_cnt * 2;
         end
         @(negedge clk);
      end
      fail_i = 1'b0; succ_i = 1'b0; busy_i = 1'b0;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule